// File: doc/BRIEF.md
# Strobe-Framed Serial Voice Sample Port

This block is the serial side of a voice-processing channel. Once per 8 kHz frame an external framer raises an enable strobe. While the strobe is high the framer toggles a bit clock, and each lane moves one PCM word in each direction. Lane 0 carries the line-receive path and lane 1 the line-send path. Each lane takes a sample in on a serial input and sends a processed sample out on a serial output. Toward the processing core the block presents one parallel word per lane with a one-cycle frame-valid pulse in the system clock domain. It also takes one parallel word per lane that it sends during the next window.

The number of bit-clock cycles inside a window sets the word format. Eight cycles select an 8-bit companded word and sixteen select a 16-bit linear word. A linear word holds a 14-bit two's complement sample, and its upper bits repeat the sample's sign bit. The bit clock may run at any rate from 128 kHz to 4.096 MHz. It may stop or run irregularly between windows, so all bit-clock logic is gated or cleared by the strobe. The window results are handed to the system clock after the strobe falls, through a synchronizer.

Top module: `pcm_serial_port`

## Requirements
- R1: With 16 bit-clock cycles in a window, `rx_word` of each lane takes the 16 bits sampled on the falling edges, first bit as MSB. Bits 15 and 14 are replaced by copies of bit 13, and `frame_wide` reads 1.
- R2: With 8 bit-clock cycles in a window, `rx_word` bits 7..0 take the 8 sampled bits, first bit as bit 7. Bits 15..8 read 0, and `frame_wide` reads 0.
- R3: After the strobe falls at the end of a window of 8 or 16 cycles, `rx_valid` is high for exactly one `clk` cycle, with the new `rx_word` present in that cycle. `rx_word` changes at no other time.
- R4: After a window with any other cycle count, no `rx_valid` pulse occurs and `rx_word` keeps its value. `frame_err` reads 1 until the next window of 8 or 16 cycles, which sets it back to 0.
- R5: `sd_out` changes on rising bit-clock edges and sends MSB first. It sends the `tx_word` value that was present at the end of the last window of 8 or 16 cycles, in that window's format. In linear format it sends bit 13 in place of bits 15 and 14.
- R6: In companded format `sd_out` sends `tx_word` bits 7..0, bit 7 first. It drives 0 on every later rising edge in the same window.
- R7: While the strobe is low, `sd_oe` reads 0 and `sd_out` reads 0. While the strobe is high, `sd_oe` reads 1.
- R8: Bit-clock edges while the strobe is low have no effect: no `rx_valid` pulse, no change of `rx_word`, and the next window is received correctly.
- R9: After reset, `rx_word` is 0, `rx_valid` and `frame_err` are 0, `frame_wide` is 1, and the words sent in the first window are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of the core-side interface |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk | input | 1 | Serial bit clock, only required inside windows |
| strobe | input | 1 | Enable strobe, high for the window |
| sd_in | input | NLANE | Serial data in per lane, sampled on bclk falling edge |
| sd_out | output | NLANE | Serial data out per lane, changes on bclk rising edge |
| sd_oe | output | 1 | Output enable for sd_out, high while strobe is high |
| tx_word | input | NLANE x LIN_W | Processed words from the core, one per lane |
| rx_word | output | NLANE x LIN_W | Received words toward the core, one per lane |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |
| frame_wide | output | 1 | Format of the last good window, 1 = linear |
| frame_err | output | 1 | Last window had an illegal bit-clock count |

## Verification
The bench builds the block with its defaults: two lanes, a 16-bit linear word holding a 14-bit sample, an 8-bit companded word and a two-stage synchronizer. Two lanes with distinct data show that the lanes do not cross. The 16/8 split lets windows alternate between formats, so a linear word is sent after a companded window and the reverse. This brings the zero tail after eight companded bits and the sign rebuild from bit 13 into reach. The short two-stage synchronizer keeps gaps between windows small, so 12- and 17-cycle windows and bit-clock toggling between windows can be mixed into one short run.

// File: rtl/pcm_port_pkg.sv
`timescale 1ns/1ps
package pcm_port_pkg;
   typedef enum logic {
      FMT_CMP = 1'b0,
      FMT_LIN = 1'b1
   } pcm_fmt_e;
endpackage

// File: rtl/pcm_win_track.sv
`timescale 1ns/1ps
module pcm_win_track #(
   parameter int CNT_W = 6
) (
   input  logic             bclk,
   input  logic             rst_n,
   input  logic             strobe,
   output logic [CNT_W-1:0] held_cnt,
   output logic [CNT_W-1:0] tx_idx
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             win_n;
   logic [CNT_W-1:0] rx_cnt;

   assign win_n = rst_n & strobe;

   // falling-edge count, cleared whenever the window is closed
   always_ff @(negedge bclk or negedge win_n) begin
      if (!win_n)                rx_cnt <= '0;
      else if (rx_cnt != CNT_MAX) rx_cnt <= rx_cnt + 1'b1;
   end

   // copy that survives the strobe fall for the system-clock side
   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n)      held_cnt <= '0;
      else if (strobe) held_cnt <= (rx_cnt == CNT_MAX) ? CNT_MAX : rx_cnt + 1'b1;
   end

   // rising-edge index of the bit to drive next
   always_ff @(posedge bclk or negedge win_n) begin
      if (!win_n)                 tx_idx <= '0;
      else if (tx_idx != CNT_MAX) tx_idx <= tx_idx + 1'b1;
   end
endmodule

// File: rtl/pcm_rx_lane.sv
`timescale 1ns/1ps
module pcm_rx_lane #(
   parameter int LIN_W = 16,
   parameter int SMP_W = 14,
   parameter int CMP_W = 8
) (
   input  logic             bclk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic             sd_in,
   output logic [LIN_W-1:0] lin_word,
   output logic [LIN_W-1:0] cmp_word
);
   logic [LIN_W-1:0] shreg;

   // shifts only inside the window, so the result holds after the strobe falls
   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n)      shreg <= '0;
      else if (strobe) shreg <= {shreg[LIN_W-2:0], sd_in};
   end

   generate
      if (SMP_W < LIN_W) begin : g_sext
         assign lin_word = {{(LIN_W-SMP_W){shreg[SMP_W-1]}}, shreg[SMP_W-1:0]};
      end else begin : g_full
         assign lin_word = shreg;
      end
   endgenerate

   assign cmp_word = {{(LIN_W-CMP_W){1'b0}}, shreg[CMP_W-1:0]};
endmodule

// File: rtl/pcm_tx_lane.sv
`timescale 1ns/1ps
module pcm_tx_lane #(
   parameter int LIN_W = 16,
   parameter int SMP_W = 14,
   parameter int CMP_W = 8,
   parameter int CNT_W = 6
) (
   input  logic             bclk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic [CNT_W-1:0] tx_idx,
   input  logic [LIN_W-1:0] word,
   input  logic             fmt_wide,
   output logic             sd_bit
);
   logic             win_n;
   logic [LIN_W-1:0] send_lin;
   logic [LIN_W-1:0] aligned;
   logic [LIN_W-1:0] shifted;

   assign win_n = rst_n & strobe;

   generate
      if (SMP_W < LIN_W) begin : g_sext
         assign send_lin = {{(LIN_W-SMP_W){word[SMP_W-1]}}, word[SMP_W-1:0]};
      end else begin : g_full
         assign send_lin = word;
      end
   endgenerate

   // companded byte is left-aligned so zeros follow it after CMP_W bits
   assign aligned = fmt_wide ? send_lin : {word[CMP_W-1:0], {(LIN_W-CMP_W){1'b0}}};
   assign shifted = aligned << tx_idx;

   always_ff @(posedge bclk or negedge win_n) begin
      if (!win_n) sd_bit <= 1'b0;
      else        sd_bit <= shifted[LIN_W-1];
   end
endmodule

// File: rtl/pcm_frame_xfer.sv
`timescale 1ns/1ps
module pcm_frame_xfer
   import pcm_port_pkg::*;
#(
   parameter int NLANE       = 2,
   parameter int LIN_W       = 16,
   parameter int CMP_W       = 8,
   parameter int CNT_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        strobe,
   input  logic [CNT_W-1:0]            held_cnt,
   input  logic [NLANE-1:0][LIN_W-1:0] rx_lin,
   input  logic [NLANE-1:0][LIN_W-1:0] rx_cmp,
   input  logic [NLANE-1:0][LIN_W-1:0] tx_word,
   output logic [NLANE-1:0][LIN_W-1:0] rx_word,
   output logic [NLANE-1:0][LIN_W-1:0] tx_hold,
   output logic                        rx_valid,
   output logic                        frame_wide,
   output logic                        frame_err
);
   localparam logic [CNT_W-1:0] N_LIN = CNT_W'(LIN_W);
   localparam logic [CNT_W-1:0] N_CMP = CNT_W'(CMP_W);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   strobe_q;
   logic                   fall;
   pcm_fmt_e               fmt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q   <= '0;
         strobe_q <= 1'b0;
      end else begin
         sync_q   <= {sync_q[SYNC_STAGES-2:0], strobe};
         strobe_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign fall = strobe_q & ~sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word   <= '0;
         tx_hold   <= '0;
         rx_valid  <= 1'b0;
         fmt_q     <= FMT_LIN;
         frame_err <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (fall) begin
            if (held_cnt == N_LIN || held_cnt == N_CMP) begin
               rx_word   <= (held_cnt == N_LIN) ? rx_lin : rx_cmp;
               fmt_q     <= (held_cnt == N_LIN) ? FMT_LIN : FMT_CMP;
               tx_hold   <= tx_word;
               rx_valid  <= 1'b1;
               frame_err <= 1'b0;
            end else begin
               frame_err <= 1'b1;
            end
         end
      end
   end

   assign frame_wide = (fmt_q == FMT_LIN);

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);                                      // R3
   AST_RX_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_word) |-> rx_valid);                              // R3
   AST_VALID_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !frame_err);                                     // R4
   AST_ERR_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_err) |-> $past(fall));                         // R4
endmodule

// File: rtl/pcm_serial_port.sv
`timescale 1ns/1ps
module pcm_serial_port #(
   parameter int NLANE       = 2,
   parameter int LIN_W       = 16,
   parameter int SMP_W       = 14,
   parameter int CMP_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bclk,
   input  logic                        strobe,
   input  logic [NLANE-1:0]            sd_in,
   output logic [NLANE-1:0]            sd_out,
   output logic                        sd_oe,
   input  logic [NLANE-1:0][LIN_W-1:0] tx_word,
   output logic [NLANE-1:0][LIN_W-1:0] rx_word,
   output logic                        rx_valid,
   output logic                        frame_wide,
   output logic                        frame_err
);
   localparam int CNT_W = $clog2(LIN_W) + 2;

   initial begin
      assert (CMP_W < LIN_W)    else $error("CMP_W must be below LIN_W");
      assert (SMP_W <= LIN_W)   else $error("SMP_W must not exceed LIN_W");
      assert (SMP_W > CMP_W)    else $error("SMP_W must exceed CMP_W");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (NLANE >= 1)       else $error("NLANE must be at least 1");
   end

   logic [CNT_W-1:0]            held_cnt;
   logic [CNT_W-1:0]            tx_idx;
   logic [NLANE-1:0][LIN_W-1:0] rx_lin;
   logic [NLANE-1:0][LIN_W-1:0] rx_cmp;
   logic [NLANE-1:0][LIN_W-1:0] tx_hold;
   logic [NLANE-1:0]            tx_bit;

   pcm_win_track #(.CNT_W(CNT_W)) u_track (
      .bclk(bclk), .rst_n(rst_n), .strobe(strobe),
      .held_cnt(held_cnt), .tx_idx(tx_idx)
   );

   generate
      for (genvar g = 0; g < NLANE; g++) begin : g_lane
         pcm_rx_lane #(.LIN_W(LIN_W), .SMP_W(SMP_W), .CMP_W(CMP_W)) u_rx (
            .bclk(bclk), .rst_n(rst_n), .strobe(strobe), .sd_in(sd_in[g]),
            .lin_word(rx_lin[g]), .cmp_word(rx_cmp[g])
         );
         pcm_tx_lane #(.LIN_W(LIN_W), .SMP_W(SMP_W), .CMP_W(CMP_W), .CNT_W(CNT_W)) u_tx (
            .bclk(bclk), .rst_n(rst_n), .strobe(strobe), .tx_idx(tx_idx),
            .word(tx_hold[g]), .fmt_wide(frame_wide), .sd_bit(tx_bit[g])
         );
         assign sd_out[g] = strobe & tx_bit[g];

         AST_LIN_SIGN_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid && frame_wide) |->
               (rx_word[g][LIN_W-1:SMP_W-1] == {(LIN_W-SMP_W+1){rx_word[g][SMP_W-1]}})); // R1
         AST_CMP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid && !frame_wide) |-> (rx_word[g][LIN_W-1:CMP_W] == '0));             // R2
      end
   endgenerate

   assign sd_oe = strobe;

   pcm_frame_xfer #(
      .NLANE(NLANE), .LIN_W(LIN_W), .CMP_W(CMP_W),
      .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_xfer (
      .clk(clk), .rst_n(rst_n), .strobe(strobe), .held_cnt(held_cnt),
      .rx_lin(rx_lin), .rx_cmp(rx_cmp), .tx_word(tx_word),
      .rx_word(rx_word), .tx_hold(tx_hold), .rx_valid(rx_valid),
      .frame_wide(frame_wide), .frame_err(frame_err)
   );
endmodule

// File: tb/sim_pcm_serial_port.sv
`timescale 1ns/1ps
module sim_pcm_serial_port;
   localparam int HB = 125;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bclk = 1'b0;
   logic             strobe = 1'b0;
   logic [1:0]       sd_in = '0;
   logic [1:0]       sd_out;
   logic             sd_oe;
   logic [1:0][15:0] tx_word = '0;
   logic [1:0][15:0] rx_word;
   logic             rx_valid;
   logic             frame_wide;
   logic             frame_err;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   typedef struct packed {
      logic [15:0] w0;
      logic [15:0] w1;
      logic        wide;
   } exp_t;
   exp_t exp_q[$];

   logic [1:0][15:0] mdl_tx = '0;
   logic             mdl_wide = 1'b1;
   logic [1:0][15:0] last_rx = '0;

   always #4 clk = ~clk;

   pcm_serial_port u0 (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .strobe(strobe),
      .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
      .tx_word(tx_word), .rx_word(rx_word), .rx_valid(rx_valid),
      .frame_wide(frame_wide), .frame_err(frame_err)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [15:0] sx(input logic [15:0] v);
      return {{2{v[13]}}, v[13:0]};
   endfunction

   function automatic logic tbit(input logic [15:0] v, input int idx);
      return (idx >= 0 && idx < 16) ? v[idx] : 1'b0;
   endfunction

   function automatic logic exp_out(input int lane, input int i);
      logic [15:0] al;
      al = mdl_wide ? sx(mdl_tx[lane]) : {mdl_tx[lane][7:0], 8'h00};
      return (i < 16) ? al[15-i] : 1'b0;
   endfunction

   // monitor: pops one expected item per valid pulse
   always @(negedge clk) begin
      if (rst_n && rx_valid && !done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected rx_valid", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(rx_word[0] == e.w0, e.wide ? "R1 lane0 word" : "R2 lane0 word", rx_word[0], e.w0);
            check(rx_word[1] == e.w1, e.wide ? "R1 lane1 word" : "R2 lane1 word", rx_word[1], e.w1);
            check(frame_wide == e.wide, "R1/R2 frame_wide", frame_wide, e.wide);
         end
      end
   end

   task automatic frame(input int nb, input logic [15:0] v0, input logic [15:0] v1);
      bit good;
      good = (nb == 8 || nb == 16);
      strobe = 1'b1;
      #20;
      check(sd_oe == 1'b1, "R7 oe in window", sd_oe, 1);
      for (int i = 0; i < nb; i++) begin
         bclk = 1'b1;
         #2;
         sd_in[0] = tbit(v0, nb-1-i);
         sd_in[1] = tbit(v1, nb-1-i);
         #(HB-4);
         for (int l = 0; l < 2; l++) begin
            logic e;
            e = exp_out(l, i);
            check(sd_out[l] == e, (!mdl_wide && i >= 8) ? "R6 tail bit" : "R5 tx bit", sd_out[l], e);
         end
         #2;
         bclk = 1'b0;
         #HB;
      end
      #20;
      strobe = 1'b0;
      if (nb == 16) begin
         exp_q.push_back({sx(v0), sx(v1), 1'b1});
         last_rx = {sx(v1), sx(v0)};
      end else if (nb == 8) begin
         exp_q.push_back({{8'h00, v0[7:0]}, {8'h00, v1[7:0]}, 1'b0});
         last_rx = {{8'h00, v1[7:0]}, {8'h00, v0[7:0]}};
      end
      if (good) begin
         mdl_wide = (nb == 16);
         mdl_tx   = tx_word;
      end
      repeat (40) @(posedge clk);
      #2;
      check(sd_oe == 1'b0, "R7 oe outside", sd_oe, 0);
      check(sd_out == 2'b00, "R7 out outside", sd_out, 0);
      check(frame_err == !good, "R4 frame_err", frame_err, !good);
      if (!good) check(rx_word == last_rx, "R4 word kept", rx_word[0], last_rx[0]);
      check(exp_q.size() == 0, "R3 valid pulse seen", exp_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #100;
      check(rx_word == '0, "R9 rx_word reset", rx_word[0], 0);
      check(rx_valid == 1'b0, "R9 rx_valid reset", rx_valid, 0);
      check(frame_err == 1'b0, "R9 frame_err reset", frame_err, 0);
      check(frame_wide == 1'b1, "R9 frame_wide reset", frame_wide, 1);
      check(sd_oe == 1'b0, "R7 oe at reset", sd_oe, 0);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);

      tx_word = {16'h0C0F, 16'h2345};
      frame(16, 16'h1ABC, 16'h2F01);   // R9 zero words sent, R1
      tx_word = {16'h00C3, 16'hF05A};
      frame(8, 16'h00A5, 16'h003C);    // R2, R5 linear send
      tx_word = {16'h3FFF, 16'h2001};
      frame(16, 16'hC123, 16'h3FFF);   // R6 companded send then zeros
      tx_word = {16'h1111, 16'h2222};
      frame(12, 16'h0ABC, 16'h0123);   // R4 short window
      frame(17, 16'hFFFF, 16'h0000);   // R4 long window

      // R8: bit-clock activity with strobe low
      for (int k = 0; k < 5; k++) begin
         sd_in = 2'(k);
         bclk = 1'b1; #60; bclk = 1'b0; #90;
      end
      repeat (20) @(posedge clk);
      #2;
      check(rx_word == last_rx, "R8 idle clocks no effect", rx_word[0], last_rx[0]);
      check(frame_err == 1'b1, "R8 err untouched by idle clocks", frame_err, 1);
      frame(16, 16'h2468, 16'h1357);   // R8 next window clean, R4 err clears

      for (int k = 0; k < 6; k++) begin
         tx_word = {16'(16'h1F00 + k * 16'h0311), 16'(16'hE00F - k * 16'h0123)};
         frame((k % 2) ? 8 : 16, 16'(16'h9000 + k * 16'h0777), 16'(16'h0F0F ^ (k * 16'h1234)));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule